// File: doc/BRIEF.md
# Multi-Lane Bonding Deskew

This block lines up several receive lanes that together carry one logical channel. The far end sends a bonding marker on every lane in the same cycle. Unequal trace or cable lengths make the copies of that marker reach the receiver in different cycles. The block notes the cycle in which each lane sees its marker and finds the lane whose marker comes last. It then delays every earlier lane through a per-lane tap delay line by exactly that lane's lead. After that, the markers leave on the same cycle, and so does every symbol sent with them.

All lanes share one clock, and every lane presents one symbol per cycle. A controller tracks the bonding process through four states:

- `ST_HUNT` waits for a marker.
- `ST_WINDOW` counts cycles after the first marker.
- `ST_BONDED` means the delays are locked and the outputs are valid.
- `ST_FAILED` means the skew window ran out and the error flag is raised.

The transitions are:

- HUNT→WINDOW: a marker arrives on some lanes but not all.
- HUNT→BONDED: markers arrive on all lanes in one cycle.
- WINDOW→BONDED: the last missing lane reports its marker.
- WINDOW→FAILED: the window expires.
- FAILED→WINDOW or FAILED→BONDED: a new marker arrives, taken the same way as from HUNT.
- BONDED→HUNT: an aligned marker shows up on some output lanes but not on all of them.

Top module: `chan_deskew`

## Requirements
- R1: After reset, `bonded`, `bond_err`, `out_sym` and `out_mark` are all zero.
- R2: While `bonded` is low, `out_sym` and `out_mark` are driven to zero on every lane.
- R3: `bonded` rises in the cycle after the clock edge that samples the last lane's marker. In that first bonded cycle, `out_mark` is set on every lane.
- R4: While bonded, output lane i (symbol bits `[i*SYM_W +: SYM_W]`, marker bit i) carries the symbol that the far end sent in the same cycle as the symbols on every other output lane. The output lags the latest lane's input by one cycle.
- R5: A skew of up to MAX_SKEW cycles between the first and the last marker arrival is accepted and bonds.
- R6: Let the first marker of a measurement arrive in cycle T. If any lane still lacks its marker after cycle T+MAX_SKEW, `bond_err` is high from the following cycle, and `bonded` stays low. A marker arriving later starts a new measurement and clears `bond_err`. `bonded` and `bond_err` are never high together.
- R7: While bonded, markers that appear on all output lanes at once keep the block bonded. A marker on some output lanes but not all drops `bonded` in the next cycle. Measurement then restarts with the next incoming marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sym | input | LANES*SYM_W | Received symbols, lane i in bits [i*SYM_W +: SYM_W] |
| in_mark | input | LANES | Bonding marker flag per lane |
| out_sym | output | LANES*SYM_W | Deskewed symbols, zero when not bonded |
| out_mark | output | LANES | Deskewed marker flags, zero when not bonded |
| bonded | output | 1 | Lanes aligned, outputs valid |
| bond_err | output | 1 | Skew window expired before all lanes reported |

## Verification
A wrong arrival record or tap shows up on the first valid output cycle. Some lanes then carry a marker while others do not, and the data words on the lanes come from different transmit cycles, so the fault is visible within one cycle of `bonded` rising. A window counter that is off by one moves the rise of `bond_err`, or the rise of `bonded` at the MAX_SKEW boundary, by one cycle. A controller that ignores misalignment keeps `bonded` high one cycle after a partial marker has reached the outputs.

// File: rtl/chan_deskew_pkg.sv
package chan_deskew_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_BONDED = 2'd2,
        ST_FAILED = 2'd3
    } bond_state_e;
endpackage

// File: rtl/lane_delay.sv
module lane_delay #(
    parameter int SYM_W    = 8,
    parameter int MAX_SKEW = 8,
    localparam int TW      = $clog2(MAX_SKEW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] d_sym,
    input  logic             d_mark,
    input  logic [TW-1:0]    tap,
    output logic [SYM_W-1:0] q_sym,
    output logic             q_mark
);
    // hist[k] holds the input sampled k+1 edges ago: {mark, sym}
    logic [SYM_W:0] hist [MAX_SKEW+1];
    logic [SYM_W:0] pick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k <= MAX_SKEW; k++) hist[k] <= '0;
        end else begin
            hist[0] <= {d_mark, d_sym};
            for (int k = 1; k <= MAX_SKEW; k++) hist[k] <= hist[k-1];
        end
    end

    always_comb begin
        pick = hist[MAX_SKEW];
        for (int k = 0; k <= MAX_SKEW; k++) begin
            if (tap == k[TW-1:0]) pick = hist[k];
        end
    end

    assign q_mark = pick[SYM_W];
    assign q_sym  = pick[SYM_W-1:0];
endmodule

// File: rtl/bond_fsm.sv
module bond_fsm
    import chan_deskew_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int MAX_SKEW = 8,
    localparam int CW      = $clog2(MAX_SKEW + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         raw_mark,
    input  logic [LANES-1:0]         al_mark,
    output logic [LANES-1:0][CW-1:0] tap_o,
    output logic                     bonded_o,
    output logic                     err_o
);
    bond_state_e             state_q, state_d;
    logic [CW-1:0]           cnt_q;
    logic [LANES-1:0]        seen_q, seen_now;
    logic [LANES-1:0][CW-1:0] arr_q, arr_now;
    logic [CW-1:0]           cnt_now;
    logic                    all_seen, partial, starting;

    always_comb begin
        starting = ((state_q == ST_HUNT) || (state_q == ST_FAILED)) && (|raw_mark);
        seen_now = (state_q == ST_WINDOW) ? (seen_q | raw_mark) : raw_mark;
        all_seen = &seen_now;
        partial  = (|al_mark) && !(&al_mark);
        cnt_now  = (state_q == ST_WINDOW) ? cnt_q : '0;
        for (int i = 0; i < LANES; i++) begin
            if (state_q == ST_WINDOW)
                arr_now[i] = (raw_mark[i] && !seen_q[i]) ? cnt_q : arr_q[i];
            else
                arr_now[i] = '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT, ST_FAILED: begin
                if (|raw_mark) state_d = all_seen ? ST_BONDED : ST_WINDOW;
            end
            ST_WINDOW: begin
                if (all_seen)
                    state_d = ST_BONDED;
                else if (cnt_q == CW'(MAX_SKEW))
                    state_d = ST_FAILED;
            end
            ST_BONDED: begin
                if (partial) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= '0;
            arr_q  <= '0;
            tap_o  <= '0;
        end else begin
            if (starting) begin
                cnt_q  <= CW'(1);
                seen_q <= raw_mark;
                arr_q  <= '0;
            end else if (state_q == ST_WINDOW) begin
                cnt_q  <= cnt_q + CW'(1);
                seen_q <= seen_now;
                arr_q  <= arr_now;
            end
            if ((state_d == ST_BONDED) && (state_q != ST_BONDED)) begin
                for (int i = 0; i < LANES; i++) tap_o[i] <= cnt_now - arr_now[i];
            end
        end
    end

    always_comb begin
        bonded_o = (state_q == ST_BONDED);
        err_o    = (state_q == ST_FAILED);
    end
endmodule

// File: rtl/chan_deskew.sv
module chan_deskew #(
    parameter int LANES    = 4,
    parameter int SYM_W    = 8,
    parameter int MAX_SKEW = 8,
    localparam int CW      = $clog2(MAX_SKEW + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*SYM_W-1:0] in_sym,
    input  logic [LANES-1:0]       in_mark,
    output logic [LANES*SYM_W-1:0] out_sym,
    output logic [LANES-1:0]       out_mark,
    output logic                   bonded,
    output logic                   bond_err
);
    logic [LANES-1:0][CW-1:0]  tap;
    logic [LANES-1:0]          al_mark;
    logic [LANES*SYM_W-1:0]    al_sym;
    logic                      bonded_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_delay #(.SYM_W(SYM_W), .MAX_SKEW(MAX_SKEW)) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_sym  (in_sym[g*SYM_W +: SYM_W]),
            .d_mark (in_mark[g]),
            .tap    (tap[g]),
            .q_sym  (al_sym[g*SYM_W +: SYM_W]),
            .q_mark (al_mark[g])
        );
    end

    bond_fsm #(.LANES(LANES), .MAX_SKEW(MAX_SKEW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_mark (in_mark),
        .al_mark  (al_mark),
        .tap_o    (tap),
        .bonded_o (bonded_w),
        .err_o    (bond_err)
    );

    assign bonded   = bonded_w;
    assign out_sym  = bonded_w ? al_sym  : '0;
    assign out_mark = bonded_w ? al_mark : '0;
endmodule

// File: rtl/chan_deskew_chk.sv
module chan_deskew_chk #(
    parameter int LANES = 4,
    parameter int SYM_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       in_mark,
    input logic [LANES*SYM_W-1:0] out_sym,
    input logic [LANES-1:0]       out_mark,
    input logic                   bonded,
    input logic                   bond_err
);
    AST_QUIET_UNBONDED: assert property (@(posedge clk) disable iff (!rst_n)
        !bonded |-> (out_mark == '0) && (out_sym == '0)); // R2
    AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bonded) |-> (&out_mark)); // R3
    AST_BOND_AFTER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bonded) |-> $past(|in_mark)); // R3
    AST_MISALIGN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bonded && (|out_mark) && !(&out_mark)) |=> !bonded); // R7
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bonded && bond_err)); // R6
    AST_ERR_FROM_UNBONDED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bond_err) |-> $past(!bonded)); // R6
endmodule

bind chan_deskew chan_deskew_chk #(.LANES(LANES), .SYM_W(SYM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_mark  (in_mark),
    .out_sym  (out_sym),
    .out_mark (out_mark),
    .bonded   (bonded),
    .bond_err (bond_err)
);

// File: tb/chan_deskew_test.sv
module chan_deskew_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int SYM_W = 8;
    localparam int MAX_SKEW = 8;
    localparam int MK1 = 5;
    localparam int MK2 = 25;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [LANES*SYM_W-1:0] in_sym = '0;
    logic [LANES-1:0]       in_mark = '0;
    logic [LANES*SYM_W-1:0] out_sym;
    logic [LANES-1:0]       out_mark;
    logic                   bonded, bond_err;

    int n_tests = 0;
    int n_fail  = 0;
    int offs [LANES];
    int stray = -1;

    chan_deskew #(.LANES(LANES), .SYM_W(SYM_W), .MAX_SKEW(MAX_SKEW)) uut (
        .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .in_mark(in_mark),
        .out_sym(out_sym), .out_mark(out_mark), .bonded(bonded), .bond_err(bond_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [SYM_W-1:0] enc(int lane, int n);
        if (n < 0) return '0;
        return {lane[1:0], n[5:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input int c);
        for (int i = 0; i < LANES; i++) begin
            int n = c - offs[i];
            in_sym[i*SYM_W +: SYM_W] = enc(i, n);
            in_mark[i] = (n == MK1) || (n == MK2) || (i == 0 && c == stray);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_sym = '0; in_mark = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // aligned data check for sample after driven cycle c, lag = max offset
    task automatic chk_data(input int c, input int lag, input string req);
        for (int i = 0; i < LANES; i++) begin
            int n = c - lag;
            chk(out_sym[i*SYM_W +: SYM_W] == enc(i, n), req,
                out_sym[i*SYM_W +: SYM_W], enc(i, n));
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(bonded == 1'b0 && bond_err == 1'b0, "R1", {bonded, bond_err}, 0);
        chk(out_sym == '0 && out_mark == '0, "R1", out_sym, 0);
    endtask

    task automatic t_bond(input int o0, input int o1, input int o2, input int o3, input string req);
        int mx, bc;
        offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3; stray = -1;
        mx = o0;
        for (int i = 1; i < LANES; i++) if (offs[i] > mx) mx = offs[i];
        bc = MK1 + mx;
        do_reset();
        for (int c = 0; c <= 42; c++) begin
            @(negedge clk);
            if (c > 0) begin
                int s = c - 1;
                if (s < bc) begin
                    chk(bonded == 1'b0, "R2", bonded, 0);
                    chk(out_sym == '0 && out_mark == '0, "R2", out_sym, 0);
                end else begin
                    chk(bonded == 1'b1, req, bonded, 1);       // R3 R5 R7 (second wave)
                    if (s == bc) chk(out_mark == '1, "R3", out_mark, 4'hF);
                    chk_data(s, mx, "R4");
                    if (s - mx == MK2) chk(out_mark == '1, "R7", out_mark, 4'hF);
                end
            end
            drive(c);
        end
    endtask

    task automatic t_overskew();
        offs[0] = 0; offs[1] = 0; offs[2] = 0; offs[3] = MAX_SKEW + 1; stray = -1;
        do_reset();
        for (int c = 0; c <= 16; c++) begin
            @(negedge clk);
            if (c > 0) begin
                int s = c - 1;
                chk(bonded == 1'b0, "R6", bonded, 0);
                if (s == MK1 + MAX_SKEW - 1) chk(bond_err == 1'b0, "R6", bond_err, 0);
                if (s == MK1 + MAX_SKEW)     chk(bond_err == 1'b1, "R6", bond_err, 1);
                if (s == MK1 + MAX_SKEW + 1) chk(bond_err == 1'b0, "R6", bond_err, 0);
            end
            drive(c);
        end
    endtask

    task automatic t_misalign();
        offs[0] = 0; offs[1] = 2; offs[2] = 1; offs[3] = 3; stray = 15;
        do_reset();
        for (int c = 0; c <= 36; c++) begin
            @(negedge clk);
            if (c > 0) begin
                int s = c - 1;
                if (s >= 8 && s <= 18) chk(bonded == 1'b1, "R7", bonded, 1);
                if (s == 18) chk(out_mark == 4'b0001, "R7", out_mark, 4'b0001);
                if (s >= 19 && s <= 27) chk(bonded == 1'b0 && out_sym == '0, "R7", bonded, 0);
                if (s == 28) chk(bonded == 1'b1 && out_mark == '1, "R7", out_mark, 4'hF);
                if (s >= 28) chk_data(s, 3, "R4");
            end
            drive(c);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_bond(0, 0, 0, 0, "R3");
        t_bond(0, 3, 1, 6, "R3");
        t_bond(MAX_SKEW, 0, 0, 0, "R5");
        t_overskew();
        t_misalign();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule